// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog timer that software controls through a small 32-bit register bus with an address, a write strobe, a read strobe, write data and read data. A down-counter runs while the watchdog is armed. Its reload length is a power of two picked by a 4-bit range field. Software keeps the system alive by writing a fixed key to a restart register. If the counter runs out, the block either pulses a system reset line at once, or first raises an interrupt and pulses reset only if the interrupt is still pending when the counter runs out a second time.

Arming is one-way. Once set, the enable bit can only be cleared by the block's reset input. A read of the interrupt-clear register acknowledges the interrupt and also restarts the count. A new range value takes effect at the next reload and does not shorten a count already in progress. A restart that lands in the same cycle as a zero count wins, and no expiry happens.

Top module: `guard_timer`

## Requirements
- R1: After reset, the control, range and status registers read 0, the counter reads 2^BASE_EXP-1, and irq and sys_rst are low.
- R2: The register map works on word addresses with the low two address bits 0: control at 0x00 (bit 0 arm, bit 1 interrupt-first mode), range at 0x04 (only bits 3:0 are stored), live counter at 0x08, restart at 0x0C, status at 0x10 (bit 0 = interrupt pending), interrupt clear at 0x14.
- R3: Once the arm bit is 1, writing 0 to it leaves it at 1 and the counter keeps running. Only rst_n clears it.
- R4: The reload value is 2^(BASE_EXP+range)-1. While armed, the counter drops by one per cycle and expires on the cycle after it reads 0. This gives an expiry every 2^(BASE_EXP+range) cycles.
- R5: While disarmed, the counter reads the full reload value of the current range from one cycle after any range write. Neither irq nor sys_rst asserts.
- R6: Writing exactly 0x00000076 to the restart register reloads the counter. Any other value written there leaves the count running.
- R7: In interrupt-first mode (control bit 1 = 1), an expiry with no pending interrupt sets irq, sets status bit 0, and reloads the counter. sys_rst stays low.
- R8: In interrupt-first mode, an expiry while irq is still pending starts a sys_rst pulse, and irq stays pending.
- R9: With control bit 1 = 0, every expiry starts a sys_rst pulse and irq never asserts.
- R10: A sys_rst pulse is high for exactly RST_LEN (default 8) cycles after the expiry edge.
- R11: A read of the interrupt-clear register clears irq and status bit 0, and reloads the counter.
- R12: Writing the range register while armed does not change the running count. The new range is used from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; only matters for the clear register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Expiry interrupt, level, pending until cleared |
| sys_rst | output | 1 | System reset pulse |

## Verification
A wrong counter state shows up at once on the live counter register, because each bench read predicts the exact value for that cycle. It also shows a period later, as irq or sys_rst switching one or more cycles off the computed expiry edge. A stale pending flag or a wrong mode decision turns into a missing or extra reset pulse at the second expiry, so the bench samples both outputs on the cycle before and the cycle after each predicted edge. The arm lock and the key check are each observed through the counter value in the cycle right after the write.

// File: rtl/guard_timer_pkg.sv
`timescale 1ns/1ps
package guard_timer_pkg;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned RANGE_W = 4;

  // word index taken from address bits [4:2]
  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_RANGE = 3'd1,
    IDX_COUNT = 3'd2,
    IDX_KICK  = 3'd3,
    IDX_STAT  = 3'd4,
    IDX_CLR   = 3'd5
  } reg_idx_e;

  // reload value for a range code: 2^(base+rng) - 1
  function automatic logic [63:0] full_count(input int unsigned base,
                                             input logic [RANGE_W-1:0] rng);
    return (64'd1 << (base + int'(rng))) - 64'd1;
  endfunction

endpackage

// File: rtl/gt_regfile.sv
`timescale 1ns/1ps
module gt_regfile
  import guard_timer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] KICK_KEY = 32'h0000_0076
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [CNT_W-1:0]      cnt_q,
  input  logic                  irq_q,
  output logic                  en_q,
  output logic                  mode_q,
  output logic [RANGE_W-1:0]    range_q,
  output logic                  kick_evt,
  output logic                  clr_evt
);

  logic     in_map;
  reg_idx_e idx;

  assign in_map = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
  assign idx    = reg_idx_e'(bus_addr[4:2]);

  logic wr_ctrl, wr_range;
  assign wr_ctrl  = bus_wr && in_map && (idx == IDX_CTRL);
  assign wr_range = bus_wr && in_map && (idx == IDX_RANGE);
  assign kick_evt = bus_wr && in_map && (idx == IDX_KICK) && (bus_wdata == KICK_KEY);
  assign clr_evt  = bus_rd && in_map && (idx == IDX_CLR);

  // arm bit can only be set by software
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      range_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= en_q | bus_wdata[0];
        mode_q <= bus_wdata[1];
      end
      if (wr_range) range_q <= bus_wdata[RANGE_W-1:0];
    end
  end

  logic [DATA_W-1:0] cnt_ext;
  assign cnt_ext = DATA_W'(cnt_q);

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      case (idx)
        IDX_CTRL:  bus_rdata = {{(DATA_W-2){1'b0}}, mode_q, en_q};
        IDX_RANGE: bus_rdata = {{(DATA_W-RANGE_W){1'b0}}, range_q};
        IDX_COUNT: bus_rdata = cnt_ext;
        IDX_STAT:  bus_rdata = {{(DATA_W-1){1'b0}}, irq_q};
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gt_downcount.sv
`timescale 1ns/1ps
module gt_downcount
  import guard_timer_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned CNT_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_q,
  input  logic [RANGE_W-1:0] range_q,
  input  logic               restart,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [CNT_W-1:0]   reload_val,
  output logic               expire_evt
);

  logic [CNT_W-1:0] reset_val;

  assign reload_val = CNT_W'(full_count(BASE_EXP, range_q));
  assign reset_val  = CNT_W'(full_count(BASE_EXP, '0));

  // a restart in the zero cycle wins over the expiry
  assign expire_evt = en_q && !restart && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= reset_val;
    else if (!en_q || restart || expire_evt)
      cnt_q <= reload_val;
    else
      cnt_q <= cnt_q - CNT_W'(1);
  end

endmodule

// File: rtl/gt_response.sv
`timescale 1ns/1ps
module gt_response #(
  parameter int unsigned RST_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_q,
  input  logic expire_evt,
  input  logic clr_evt,
  output logic irq_q,
  output logic fire_evt,
  output logic sys_rst
);

  localparam int unsigned RW = $clog2(RST_LEN + 1);

  logic [RW-1:0] rst_left;

  // reset now in direct mode, or on a second expiry with irq still pending
  assign fire_evt = expire_evt && (!mode_q || irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else if (clr_evt)
      irq_q <= 1'b0;
    else if (expire_evt && mode_q)
      irq_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_left <= '0;
    else if (fire_evt)
      rst_left <= RW'(RST_LEN);
    else if (rst_left != '0)
      rst_left <= rst_left - RW'(1);
  end

  assign sys_rst = (rst_left != '0);

endmodule

// File: rtl/guard_timer.sv
`timescale 1ns/1ps
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned RST_LEN  = 8,
  parameter logic [31:0] KICK_KEY = 32'h0000_0076
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              sys_rst
);

  localparam int unsigned CNT_W = BASE_EXP + 16;

  // named internal events, observed by the bound checker
  logic               en_q;
  logic               mode_q;
  logic [RANGE_W-1:0] range_q;
  logic               kick_evt;
  logic               clr_evt;
  logic               restart;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   reload_val;
  logic               expire_evt;
  logic               fire_evt;
  logic               irq_q;

  assign restart = kick_evt || clr_evt;
  assign irq     = irq_q;

  gt_regfile #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .KICK_KEY(KICK_KEY)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt_q    (cnt_q),
    .irq_q    (irq_q),
    .en_q     (en_q),
    .mode_q   (mode_q),
    .range_q  (range_q),
    .kick_evt (kick_evt),
    .clr_evt  (clr_evt)
  );

  gt_downcount #(
    .BASE_EXP(BASE_EXP),
    .CNT_W   (CNT_W)
  ) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_q      (en_q),
    .range_q   (range_q),
    .restart   (restart),
    .cnt_q     (cnt_q),
    .reload_val(reload_val),
    .expire_evt(expire_evt)
  );

  gt_response #(
    .RST_LEN(RST_LEN)
  ) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .expire_evt(expire_evt),
    .clr_evt   (clr_evt),
    .irq_q     (irq_q),
    .fire_evt  (fire_evt),
    .sys_rst   (sys_rst)
  );

endmodule

// File: rtl/guard_timer_chk.sv
`timescale 1ns/1ps
module guard_timer_chk #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned RST_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             mode_q,
  input logic             irq,
  input logic             sys_rst,
  input logic             expire_evt,
  input logic             fire_evt,
  input logic             kick_evt,
  input logic             clr_evt,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_val
);

  localparam int unsigned SW = $clog2(RST_LEN + 2) + 1;
  localparam logic [SW-1:0] SMAX = {SW{1'b1}};

  // cycles since the last reset pulse was launched (0 = never)
  logic [SW-1:0] since_fire;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_fire <= '0;
    else if (fire_evt)
      since_fire <= SW'(1);
    else if (since_fire != '0 && since_fire != SMAX)
      since_fire <= since_fire + SW'(1);
  end

  assert_arm_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !kick_evt && !clr_evt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_quiet_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!irq && !sys_rst));

  assert_kick_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    kick_evt |=> (cnt_q == $past(reload_val)));

  assert_irq_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && mode_q && !irq) |=> irq);

  assert_second_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && mode_q && irq) |=> (sys_rst && irq));

  assert_direct_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_evt && !mode_q && !irq) |=> (sys_rst && !irq));

  assert_pulse_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst == (since_fire != '0 && since_fire <= SW'(RST_LEN)));

  assert_clear_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !irq);

endmodule

bind guard_timer guard_timer_chk #(
  .CNT_W  (CNT_W),
  .RST_LEN(RST_LEN)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_q      (en_q),
  .mode_q    (mode_q),
  .irq       (irq),
  .sys_rst   (sys_rst),
  .expire_evt(expire_evt),
  .fire_evt  (fire_evt),
  .kick_evt  (kick_evt),
  .clr_evt   (clr_evt),
  .cnt_q     (cnt_q),
  .reload_val(reload_val)
);

// File: tb/test_guard_timer.sv
`timescale 1ns/1ps
module test_guard_timer;

  localparam int BASE = 2;
  localparam logic [4:0] A_CTRL = 5'h00, A_RANGE = 5'h04, A_COUNT = 5'h08,
                         A_KICK = 5'h0C, A_STAT = 5'h10, A_CLR = 5'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sys_rst;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  guard_timer #(.BASE_EXP(BASE)) i_guard_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sys_rst(sys_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  function automatic int per(int r);
    int p = 1;
    for (int i = 0; i < BASE + r; i++) p = p * 2;
    return p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic peek(logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic read_clr();
    bus_addr = A_CLR; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  initial begin
    logic [31:0] v, c1;
    int p;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    peek(A_CTRL, v);  chk("R1 ctrl", v, 0);
    peek(A_RANGE, v); chk("R1 range", v, 0);
    peek(A_COUNT, v); chk("R1 count", v, per(0) - 1);
    peek(A_STAT, v);  chk("R1 stat", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 sys_rst", {31'b0, sys_rst}, 0);

    // R5 disarmed: holds, stays quiet
    tick(40);
    peek(A_COUNT, v); chk("R5 hold", v, per(0) - 1);
    chk("R5 irq", {31'b0, irq}, 0);
    chk("R5 sys_rst", {31'b0, sys_rst}, 0);

    // R4 / R5 reload value for every range code
    for (int r = 0; r < 16; r++) begin
      wr(A_RANGE, r);
      tick(1);
      peek(A_COUNT, v); chk("R4 reload value", v, per(r) - 1);
    end
    // R2 range keeps bits 3:0 only
    wr(A_RANGE, 32'hFFFF_FFF5);
    peek(A_RANGE, v); chk("R2 range field", v, 5);

    // R7 / R8 interrupt-first sweep
    for (int r = 0; r < 5; r++) begin
      do_reset();
      p = per(r);
      wr(A_RANGE, r);
      wr(A_CTRL, 3);
      peek(A_CTRL, v); chk("R2 ctrl bits", v, 3);
      tick(p / 2);
      peek(A_COUNT, v); chk("R4 mid count", v, p - 1 - p / 2);
      tick(p - 1 - p / 2);
      peek(A_COUNT, v); chk("R4 zero", v, 0);
      chk("R7 no early irq", {31'b0, irq}, 0);
      tick(1);
      chk("R7 irq on first expiry", {31'b0, irq}, 1);
      chk("R7 no reset yet", {31'b0, sys_rst}, 0);
      peek(A_STAT, v); chk("R7 status bit", v, 1);
      peek(A_COUNT, v); chk("R7 reload", v, p - 1);
      tick(p - 1);
      chk("R8 no early reset", {31'b0, sys_rst}, 0);
      tick(1);
      chk("R8 reset on second expiry", {31'b0, sys_rst}, 1);
      chk("R8 irq kept", {31'b0, irq}, 1);
    end

    // R9 direct reset sweep
    for (int r = 0; r < 5; r++) begin
      do_reset();
      p = per(r);
      wr(A_RANGE, r);
      wr(A_CTRL, 1);
      tick(p - 1);
      chk("R9 no early reset", {31'b0, sys_rst}, 0);
      tick(1);
      chk("R9 reset on expiry", {31'b0, sys_rst}, 1);
      chk("R9 no irq", {31'b0, irq}, 0);
      tick(p);
      chk("R9 still no irq", {31'b0, irq}, 0);
    end

    // R10 pulse width
    do_reset();
    p = per(3);
    wr(A_RANGE, 3);
    wr(A_CTRL, 1);
    tick(p);
    chk("R10 pulse start", {31'b0, sys_rst}, 1);
    tick(7);
    chk("R10 pulse 8th cycle", {31'b0, sys_rst}, 1);
    tick(1);
    chk("R10 pulse ended", {31'b0, sys_rst}, 0);

    // R3 arm lock
    wr(A_CTRL, 0);
    peek(A_CTRL, v); chk("R3 arm kept", v, 1);
    peek(A_COUNT, c1);
    tick(1);
    peek(A_COUNT, v); chk("R3 still counting", v, c1 - 1);
    do_reset();
    peek(A_CTRL, v); chk("R3 cleared by reset", v, 0);

    // R6 restart key
    do_reset();
    wr(A_RANGE, 3);
    wr(A_CTRL, 3);
    tick(20);
    peek(A_COUNT, v); chk("R6 before kick", v, 11);
    wr(A_KICK, 32'h76);
    peek(A_COUNT, v); chk("R6 key reloads", v, 31);
    wr(A_KICK, 32'h77);
    peek(A_COUNT, v); chk("R6 wrong key ignored", v, 30);
    wr(A_KICK, 32'h176);
    peek(A_COUNT, v); chk("R6 wide wrong key ignored", v, 29);
    for (int i = 0; i < 10; i++) begin
      tick(20);
      wr(A_KICK, 32'h76);
    end
    chk("R6 kicks hold off irq", {31'b0, irq}, 0);

    // R11 clear read
    do_reset();
    p = per(2);
    wr(A_RANGE, 2);
    wr(A_CTRL, 3);
    tick(p);
    chk("R11 irq set", {31'b0, irq}, 1);
    tick(3);
    peek(A_COUNT, v); chk("R11 count before clear", v, p - 4);
    read_clr();
    chk("R11 irq cleared", {31'b0, irq}, 0);
    peek(A_STAT, v); chk("R11 status cleared", v, 0);
    peek(A_COUNT, v); chk("R11 reload", v, p - 1);
    tick(p);
    chk("R11 irq again", {31'b0, irq}, 1);
    chk("R11 no reset after clear", {31'b0, sys_rst}, 0);

    // R12 range change mid-count
    do_reset();
    wr(A_RANGE, 3);
    wr(A_CTRL, 3);
    tick(10);
    peek(A_COUNT, v); chk("R12 before change", v, 21);
    wr(A_RANGE, 1);
    peek(A_COUNT, v); chk("R12 count unaffected", v, 20);
    tick(20);
    chk("R12 old period runs out", {31'b0, irq}, 0);
    tick(1);
    chk("R12 expiry", {31'b0, irq}, 1);
    peek(A_COUNT, v); chk("R12 new reload", v, per(1) - 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule